// File: doc/BRIEF.md
# Store Buffer Forwarding Filter

This block sits between a core's store pipeline and its memory write port. Plain stores and the store halves of atomic read-modify-write and store-conditional operations enter with a byte address, a size code, little-endian data and an atomic tag. Each entry covers one aligned 8-byte line, with a byte mask and 8 lanes of data. A store that crosses a line boundary is split into two entries. Entries leave one per cycle, oldest first, through a valid/ready write port.

Younger loads probe the buffer combinationally. A load that an overlapping plain store fully covers receives that store's bytes. A load that touches no buffered byte is reported as a miss, so memory can serve it. Any other overlap gives a stall:

- the youngest overlapping entry covers the load only partly, or
- the youngest overlapping entry is atomic.

A stalled load retries after the blocking entry drains. Atomic data is never forwarded, even when the stored value does not depend on memory. A load that crosses a line boundary is checked one line at a time, and the two results are then combined.

Top module: `sbuf_fwd_filter`

## Requirements
- R1: After reset the buffer is empty: `dr_valid` is 0, `enq_ready` is 1, and any lookup returns result code 0.
- R2: A store is taken when `enq_valid` and `enq_ready` are both 1. Size code 0/1/2/3 means 1/2/4/8 bytes, starting at `enq_addr`, with the value in the low bytes of `enq_data`. A store inside one aligned 8-byte line uses one entry. A store that crosses a line boundary uses two entries, the lower line first.
- R3: Entries drain strictly in the order they were accepted, one per cycle in which `dr_valid` and `dr_ready` are both 1. While `dr_ready` is 0, the drain outputs hold. `dr_addr` is the line's byte address with its low 3 bits zero. Bit i of `dr_mask` marks byte i of `dr_data`.
- R4: `enq_ready` is 0 when the buffer is full. It is also 0 when only one slot is free and the offered store crosses a line.
- R5: An enqueue and a drain may complete in the same cycle. The oldest entry leaves, and the new store is appended behind the others.
- R6: When every byte a load needs is covered by the youngest overlapping plain store, `ld_result` is 1 (forward). `ld_data` then holds the load's bytes in its low bytes, with the rest zero.
- R7: When no buffered entry shares any byte with the load, `ld_result` is 0 and `ld_data` is 0.
- R8: When the youngest entry overlapping the load is atomic, `ld_result` is 2 (stall), even if that entry covers the load fully. The stall lasts until that entry has drained.
- R9: When the youngest overlapping entry covers only part of the load's bytes in that line, `ld_result` is 2. Bytes are not merged from several entries.
- R10: When several entries overlap a load, only the youngest one decides the result. This holds both when the youngest is a plain store over an older atomic one, and when the youngest covers less than an older store.
- R11: A load that crosses a line is checked per line. It forwards only if both lines forward. It misses only if both lines miss. Any other mix gives 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Store offered |
| enq_ready | output | 1 | Enough free slots for the offered store |
| enq_addr | input | AW | Store byte address |
| enq_size | input | 2 | Store size code (1, 2, 4, 8 bytes) |
| enq_data | input | 64 | Store value in the low bytes |
| enq_atomic | input | 1 | Store belongs to an atomic or conditional operation |
| dr_valid | output | 1 | Oldest entry available to write |
| dr_ready | input | 1 | Memory accepts the oldest entry |
| dr_addr | output | AW | Line byte address of the oldest entry |
| dr_mask | output | 8 | Byte enables of the oldest entry |
| dr_data | output | 64 | Line data of the oldest entry |
| dr_atomic | output | 1 | Oldest entry is atomic |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_result | output | 2 | 0 miss, 1 forward, 2 stall |
| ld_data | output | 64 | Forwarded bytes, low-aligned |

## Verification
The bench probes an atomic entry that fully covers a load. A filter that forwarded from atomics would return its data instead of stalling. It layers entries so that the youngest overlap is plain over atomic, and narrow over wide. A design that scanned oldest-first, or merged bytes, would forward stale or stitched values. It splits a store across a line boundary and loads across the same boundary, both fully covered and half covered. A design without per-line checking would forward a half-covered load or lose the upper bytes. It also fills the buffer to its edge and drains while enqueuing, so an off-by-one ready or a pointer slip shows up as an accepted store past capacity or an out-of-order drain address.

// File: rtl/sbuf_fwd_filter.sv
`timescale 1ns/1ps
module sbuf_fwd_filter #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int LANES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [AW-1:0]     enq_addr,
  input  logic [1:0]        enq_size,
  input  logic [LANES*8-1:0] enq_data,
  input  logic              enq_atomic,
  output logic              dr_valid,
  input  logic              dr_ready,
  output logic [AW-1:0]     dr_addr,
  output logic [LANES-1:0]  dr_mask,
  output logic [LANES*8-1:0] dr_data,
  output logic              dr_atomic,
  input  logic              ld_valid,
  input  logic [AW-1:0]     ld_addr,
  input  logic [1:0]        ld_size,
  output logic [1:0]        ld_result,
  output logic [LANES*8-1:0] ld_data
);
  localparam int DW = LANES * 8;
  localparam int ML = 2 * LANES;
  localparam int OW = $clog2(LANES);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int LW = AW - OW;
  localparam logic [1:0] RES_MISS  = 2'd0;
  localparam logic [1:0] RES_FWD   = 2'd1;
  localparam logic [1:0] RES_STALL = 2'd2;

  function automatic logic [ML-1:0] span(input logic [1:0] sz, input logic [OW-1:0] off);
    logic [ML-1:0] b;
    case (sz)
      2'd0:    b = ML'(8'h01);
      2'd1:    b = ML'(8'h03);
      2'd2:    b = ML'(8'h0F);
      default: b = ML'(8'hFF);
    endcase
    return b << off;
  endfunction

  function automatic logic [DW-1:0] widen(input logic [LANES-1:0] m);
    logic [DW-1:0] r;
    for (int i = 0; i < LANES; i++) r[8*i +: 8] = {8{m[i]}};
    return r;
  endfunction

  logic [LW-1:0]    e_line [DEPTH];
  logic [LANES-1:0] e_mask [DEPTH];
  logic [DW-1:0]    e_data [DEPTH];
  logic             e_atom [DEPTH];
  logic [PW-1:0]    head, tail;
  logic [CW-1:0]    count;

  // enqueue side: place the store across two line slots
  logic [OW-1:0] enq_off;
  logic [LW-1:0] enq_line;
  logic [ML-1:0] enq_m2;
  logic [2*DW-1:0] enq_d2;
  logic enq_cross, push, pop;

  assign enq_off   = enq_addr[OW-1:0];
  assign enq_line  = enq_addr[AW-1:OW];
  assign enq_m2    = span(enq_size, enq_off);
  assign enq_d2    = {{DW{1'b0}}, enq_data} << {enq_off, 3'b000};
  assign enq_cross = |enq_m2[ML-1:LANES];
  assign enq_ready = (count <= CW'(DEPTH - 2)) || (count == CW'(DEPTH - 1) && !enq_cross);
  assign push      = enq_valid && enq_ready;
  assign pop       = dr_valid && dr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        e_line[tail] <= enq_line;
        e_mask[tail] <= enq_m2[LANES-1:0];
        e_data[tail] <= enq_d2[DW-1:0];
        e_atom[tail] <= enq_atomic;
        if (enq_cross) begin
          e_line[tail + PW'(1)] <= enq_line + LW'(1);
          e_mask[tail + PW'(1)] <= enq_m2[ML-1:LANES];
          e_data[tail + PW'(1)] <= enq_d2[2*DW-1:DW];
          e_atom[tail + PW'(1)] <= enq_atomic;
        end
        tail <= tail + (enq_cross ? PW'(2) : PW'(1));
      end
      if (pop) head <= head + PW'(1);
      count <= count + (push ? (enq_cross ? CW'(2) : CW'(1)) : CW'(0)) - CW'(pop);
    end
  end

  assign dr_valid  = (count != '0);
  assign dr_addr   = {e_line[head], {OW{1'b0}}};
  assign dr_mask   = e_mask[head];
  assign dr_data   = e_data[head];
  assign dr_atomic = e_atom[head];

  // lookup side: each line of the load finds its youngest overlapping entry
  logic [OW-1:0] ld_off;
  logic [LW-1:0] ld_line;
  logic [ML-1:0] ld_m2, ld_szm;
  logic [3:0]    comp_res;
  logic [2*DW-1:0] comp_data;

  assign ld_off  = ld_addr[OW-1:0];
  assign ld_line = ld_addr[AW-1:OW];
  assign ld_m2   = span(ld_size, ld_off);
  assign ld_szm  = span(ld_size, '0);

  for (genvar c = 0; c < 2; c++) begin : g_comp
    logic [LW-1:0]    line;
    logic [LANES-1:0] need;
    logic             hit;
    logic [PW-1:0]    hidx, idx;
    assign line = ld_line + LW'(c);
    assign need = ld_m2[c*LANES +: LANES];
    always_comb begin
      hit  = 1'b0;
      hidx = '0;
      idx  = '0;
      for (int k = 0; k < DEPTH; k++) begin
        idx = head + PW'(k);
        if (CW'(k) < count && e_line[idx] == line && |(e_mask[idx] & need)) begin
          hit  = 1'b1;
          hidx = idx;
        end
      end
    end
    assign comp_res[2*c +: 2] = (need == '0 || !hit) ? RES_MISS :
                                (e_atom[hidx] || (e_mask[hidx] & need) != need) ? RES_STALL : RES_FWD;
    assign comp_data[c*DW +: DW] = e_data[hidx];
  end

  logic any_stall, all_fwd, all_miss;
  logic [2*DW-1:0] aligned;
  assign any_stall = comp_res[1:0] == RES_STALL || comp_res[3:2] == RES_STALL;
  assign all_fwd   = comp_res[1:0] == RES_FWD && (ld_m2[ML-1:LANES] == '0 || comp_res[3:2] == RES_FWD);
  assign all_miss  = comp_res[1:0] == RES_MISS && comp_res[3:2] == RES_MISS;
  assign aligned   = comp_data >> {ld_off, 3'b000};
  assign ld_result = !ld_valid ? RES_MISS :
                     any_stall ? RES_STALL :
                     all_fwd   ? RES_FWD :
                     all_miss  ? RES_MISS : RES_STALL;
  assign ld_data   = (ld_result == RES_FWD) ? (aligned[DW-1:0] & widen(ld_szm[LANES-1:0])) : '0;

  p_full_blocks_enq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count == CW'(DEPTH) |-> !enq_ready);
  p_capacity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_drain_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid && !dr_ready |=> dr_valid && $stable(dr_addr) && $stable(dr_mask)
                              && $stable(dr_data) && $stable(dr_atomic));
  p_empty_misses_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_valid |-> ld_result == RES_MISS && ld_data == '0);
  p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_result != 2'd3);
endmodule

// File: tb/sbuf_fwd_filter_test.sv
`timescale 1ns/1ps
module sbuf_fwd_filter_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, enq_valid, enq_ready, enq_atomic, dr_valid, dr_ready, dr_atomic, ld_valid;
  logic [31:0] enq_addr, dr_addr, ld_addr;
  logic [1:0]  enq_size, ld_size, ld_result;
  logic [63:0] enq_data, dr_data, ld_data;
  logic [7:0]  dr_mask;
  int checks = 0, errors = 0;
  bit done = 0;

  sbuf_fwd_filter uut (.*);

  function automatic logic [63:0] bytes_of(input logic [7:0] m);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = {8{m[i]}};
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [1:0] s, input logic [63:0] d, input bit at);
    @(negedge clk);
    enq_valid = 1; enq_addr = a; enq_size = s; enq_data = d; enq_atomic = at;
    @(posedge clk); #1;
    enq_valid = 0; enq_atomic = 0;
  endtask

  task automatic look(input logic [31:0] a, input logic [1:0] s, input logic [1:0] er,
                      input logic [63:0] ed, input string req);
    @(negedge clk);
    ld_valid = 1; ld_addr = a; ld_size = s;
    #1;
    check(ld_result == er, req, 64'(ld_result), 64'(er));
    check(ld_data == ed, req, ld_data, ed);
    ld_valid = 0;
  endtask

  task automatic take(input logic [31:0] ea, input logic [7:0] em, input logic [63:0] ed,
                      input bit eat, input string req);
    @(negedge clk);
    check(dr_valid, req, 64'(dr_valid), 64'd1);
    check(dr_addr == ea, req, 64'(dr_addr), 64'(ea));
    check(dr_mask == em, req, 64'(dr_mask), 64'(em));
    check((dr_data & bytes_of(dr_mask)) == ed, req, dr_data & bytes_of(dr_mask), ed);
    check(dr_atomic == eat, req, 64'(dr_atomic), 64'(eat));
    dr_ready = 1;
    @(posedge clk); #1;
    dr_ready = 0;
  endtask

  task automatic flush;
    @(negedge clk);
    dr_ready = 1;
    while (dr_valid) @(negedge clk);
    dr_ready = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(dr_valid == 0, "R1 empty", 64'(dr_valid), 64'd0);
    check(enq_ready == 1, "R1 ready", 64'(enq_ready), 64'd1);
    look(32'h100, 2'd3, 2'd0, 64'd0, "R1 lookup");
  endtask

  task automatic t_forward_atomic;
    put(32'h100, 2'd3, 64'h1122334455667788, 0);
    look(32'h104, 2'd2, 2'd1, 64'h11223344, "R6 word");
    look(32'h101, 2'd0, 2'd1, 64'h77, "R6 byte");
    look(32'h200, 2'd3, 2'd0, 64'd0, "R7 miss");
    put(32'h300, 2'd2, 64'hAABBCCDD, 1);
    look(32'h300, 2'd2, 2'd2, 64'd0, "R8 atomic full cover");
    take(32'h100, 8'hFF, 64'h1122334455667788, 0, "R3 first");
    look(32'h302, 2'd0, 2'd2, 64'd0, "R8 still queued");
    take(32'h300, 8'h0F, 64'hAABBCCDD, 1, "R3 second");
    look(32'h300, 2'd2, 2'd0, 64'd0, "R8 after drain");
  endtask

  task automatic t_priority;
    put(32'h400, 2'd3, 64'h0, 1);
    put(32'h400, 2'd3, 64'hCAFEF00D12345678, 0);
    look(32'h400, 2'd3, 2'd1, 64'hCAFEF00D12345678, "R10 plain over atomic");
    put(32'h480, 2'd3, 64'h1, 0);
    put(32'h480, 2'd3, 64'h2, 1);
    look(32'h480, 2'd3, 2'd2, 64'd0, "R10 atomic over plain");
    flush();
    put(32'h600, 2'd2, 64'h11111111, 0);
    put(32'h600, 2'd2, 64'h22222222, 0);
    look(32'h600, 2'd2, 2'd1, 64'h22222222, "R10 youngest value");
    put(32'h602, 2'd0, 64'h55, 0);
    look(32'h600, 2'd2, 2'd2, 64'd0, "R10 narrow youngest");
    look(32'h602, 2'd0, 2'd1, 64'h55, "R10 narrow byte");
    flush();
  endtask

  task automatic t_partial;
    put(32'h500, 2'd1, 64'hBEEF, 0);
    look(32'h500, 2'd2, 2'd2, 64'd0, "R9 partial");
    look(32'h500, 2'd0, 2'd1, 64'hEF, "R9 inside low");
    look(32'h501, 2'd0, 2'd1, 64'hBE, "R9 inside high");
    flush();
  endtask

  task automatic t_misaligned;
    put(32'h706, 2'd2, 64'hDDCCBBAA, 0);
    look(32'h706, 2'd2, 2'd1, 64'hDDCCBBAA, "R11 both lines");
    look(32'h708, 2'd1, 2'd1, 64'hDDCC, "R11 upper line");
    take(32'h700, 8'hC0, 64'hBBAA000000000000, 0, "R2 lower line first");
    take(32'h708, 8'h03, 64'h000000000000DDCC, 0, "R2 upper line");
    put(32'h7FE, 2'd1, 64'h1234, 0);
    look(32'h7FE, 2'd2, 2'd2, 64'd0, "R11 mixed lines");
    flush();
  endtask

  task automatic t_full;
    for (int i = 0; i < 7; i++) put(32'h800 + 32'(8*i), 2'd3, {8{8'(i)}}, 0);
    @(negedge clk);
    enq_addr = 32'h8FE; enq_size = 2'd2; #1;
    check(enq_ready == 0, "R4 one slot crossing", 64'(enq_ready), 64'd0);
    enq_addr = 32'h900; enq_size = 2'd3; #1;
    check(enq_ready == 1, "R4 one slot aligned", 64'(enq_ready), 64'd1);
    @(negedge clk);
    enq_valid = 1; enq_addr = 32'h900; enq_size = 2'd3; enq_data = {8{8'h99}};
    dr_ready = 1;
    #1;
    check(dr_addr == 32'h800, "R5 head leaving", 64'(dr_addr), 64'h800);
    @(posedge clk); #1;
    enq_valid = 0; dr_ready = 0;
    put(32'h908, 2'd3, {8{8'hA5}}, 0);
    @(negedge clk);
    enq_addr = 32'hA00; enq_size = 2'd0; #1;
    check(enq_ready == 0, "R4 full", 64'(enq_ready), 64'd0);
    look(32'h900, 2'd3, 2'd1, {8{8'h99}}, "R5 same-cycle store visible");
    for (int i = 1; i < 7; i++) take(32'h800 + 32'(8*i), 8'hFF, {8{8'(i)}}, 0, "R3 order");
    take(32'h900, 8'hFF, {8{8'h99}}, 0, "R5 appended");
    take(32'h908, 8'hFF, {8{8'hA5}}, 0, "R3 last");
    @(negedge clk);
    check(dr_valid == 0, "R3 empty after drain", 64'(dr_valid), 64'd0);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    rst_n = 0; enq_valid = 0; enq_atomic = 0; enq_addr = 0; enq_size = 0; enq_data = 0;
    dr_ready = 0; ld_valid = 0; ld_addr = 0; ld_size = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_forward_atomic();
    t_priority();
    t_partial();
    t_misaligned();
    t_full();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule